// File: doc/BRIEF.md
# ATA Channel Soft-Reset Sequencer

This block runs the host side of a software reset on one parallel ATA channel. After a start request it talks to the channel's task-file registers through a simple register-access port: it pulses the reset bit in the device-control register, polls the status register until the busy flag drops, proves that device 1 can be selected by reading the device/head register back, puts device 0 back in the select register, and, for a non-packet drive, waits for the ready flag. It always finishes by re-enabling interrupts in the device-control register.

Each wait is bounded by a cycle-count deadline, and the select retry loop shares one deadline for all its attempts. The outcome comes out as a one-cycle `done` or `timeout` pulse, together with the last status byte the sequencer read. Both the settle delay after a select and the deadline are parameters given in clock cycles, so a simulation can shorten them.

Top module: `chan_reset_seq`

## Requirements
- R1: While and after reset, and before the first start, `bus_req`, `done` and `timeout` are 0 and `status` is 0x00.
- R2: Every register access raises `bus_req` and holds `bus_addr`, `bus_wr` and `bus_wdata` steady until the cycle in which `bus_ack` is high. Each acknowledged request is exactly one access. Register addresses: device control = 2, device/head = 6, status = 7.
- R3: A sequence opens with two device-control writes: first 0x0E, then 0x0A (bit 3 = legacy head bit, bit 2 = soft reset, bit 1 = interrupt disable).
- R4: After reset is released, the status register is read again and again until bit 7 (busy) reads 0.
- R5: The sequencer writes 0xB0 (device 1) to device/head, then lets at least DLY_CYC clock cycles pass before the next status read, polls until busy is clear, and then reads device/head back.
- R6: When the read-back value is not 0xB0, the select, the delay, the busy poll and the read-back are repeated until one deadline, started at the first select, runs out.
- R7: Once device 1 has been confirmed, 0xA0 (device 0) is written to device/head.
- R8: When `drive_is_ata` is 1 at start, the sequencer then polls status until bit 6 (ready) is 1. When it is 0 (packet drive), no ready wait takes place.
- R9: On every outcome, timeouts included, the last access of a sequence writes 0x08 to device control.
- R10: A wait that is still unsatisfied when its deadline of TMO_CYC cycles has passed ends the sequence with a timeout.
- R11: `done` and `timeout` are one-cycle pulses that never occur together. `status` carries the last status byte read.
- R12: A start request that arrives while a sequence is running has no effect: no extra access and no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reset sequence (accepted only while idle) |
| drive_is_ata | input | 1 | 1 = non-packet ATA drive, 0 = packet drive; sampled at start |
| bus_req | output | 1 | Register access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle pulse: sequence succeeded |
| timeout | output | 1 | One-cycle pulse: a wait exceeded its deadline |
| status | output | 8 | Last status byte read |

## Verification
The bench goes after the select retry loop with a device model that ignores the device-1 write a set number of times. A design that skips the read-back would write 0xB0 only once, and one that never gives up would hang on a device that ignores every select. A device held busy forever and a non-packet drive that never reports ready must both end in a timeout that is still preceded by the 0x08 re-enable write; a design that leaves early on failure would miss that write. A packet drive with the ready flag clear must finish with `done`, which shows the ready wait is skipped, and a second start pulse in the middle of a run must leave the access trace and the result count unchanged.

// File: rtl/chan_rst_pkg.sv
package chan_rst_pkg;

    typedef logic [2:0] reg_addr_t;
    typedef logic [7:0] byte_t;

    localparam reg_addr_t A_DEVCTL  = 3'd2;
    localparam reg_addr_t A_DEVHEAD = 3'd6;
    localparam reg_addr_t A_STATUS  = 3'd7;

    localparam byte_t CTL_HD15 = 8'h08;
    localparam byte_t CTL_SRST = 8'h04;
    localparam byte_t CTL_NIEN = 8'h02;

    localparam byte_t DH_DEV0 = 8'hA0;
    localparam byte_t DH_DEV1 = 8'hB0;

    localparam byte_t ST_BSY = 8'h80;
    localparam byte_t ST_RDY = 8'h40;

    typedef struct packed {
        reg_addr_t addr;
        logic      wr;
        byte_t     wdata;
    } bus_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ASSERT,
        S_RELEASE,
        S_BSY_RD,
        S_SEL1,
        S_SEL_DLY,
        S_SEL_BSY,
        S_DH_RD,
        S_SEL0,
        S_RDY_RD,
        S_REARM,
        S_REPORT
    } seq_state_t;

    function automatic bus_op_t op_write(reg_addr_t a, byte_t d);
        bus_op_t o;
        o.addr  = a;
        o.wr    = 1'b1;
        o.wdata = d;
        return o;
    endfunction

    function automatic bus_op_t op_read(reg_addr_t a);
        bus_op_t o;
        o.addr  = a;
        o.wr    = 1'b0;
        o.wdata = 8'h00;
        return o;
    endfunction

    function automatic logic flag_set(byte_t value, byte_t mask);
        return (value & mask) != 8'h00;
    endfunction

endpackage

// File: rtl/rst_cycle_timer.sv
module rst_cycle_timer #(
    parameter longint unsigned LIMIT = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM_V);
endmodule

// File: rtl/rst_bus_master.sv
module rst_bus_master
    import chan_rst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  bus_op_t   op,
    output logic      xfer_done,
    output byte_t     xfer_rdata,
    output logic      bus_req,
    output logic      bus_wr,
    output reg_addr_t bus_addr,
    output byte_t     bus_wdata,
    input  logic      bus_ack,
    input  byte_t     bus_rdata
);
    bus_op_t held;
    logic    req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            held  <= '0;
        end else if (issue) begin
            req_q <= 1'b1;
            held  <= op;
        end else if (req_q && bus_ack) begin
            req_q <= 1'b0;
        end
    end

    assign xfer_done  = req_q && bus_ack;
    assign xfer_rdata = bus_rdata;
    assign bus_req    = req_q;
    assign bus_wr     = held.wr;
    assign bus_addr   = held.addr;
    assign bus_wdata  = held.wdata;
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import chan_rst_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    drive_is_ata,
    input  logic    xfer_done,
    input  byte_t   xfer_rdata,
    output logic    issue,
    output bus_op_t op,
    output logic    dly_clr,
    input  logic    dly_exp,
    output logic    dl_clr,
    input  logic    dl_exp,
    output logic    done,
    output logic    timeout,
    output byte_t   status
);
    seq_state_t st;
    logic       pend;
    logic       ata_q;
    logic       fail_q;
    byte_t      stat_q;
    logic       op_state;
    logic       rd_busy;
    logic       rd_ready;
    logic       dh_match;

    assign rd_busy  = flag_set(xfer_rdata, ST_BSY);
    assign rd_ready = flag_set(xfer_rdata, ST_RDY);
    assign dh_match = (xfer_rdata == DH_DEV1);

    // Access chosen by the current step.
    always_comb begin
        op_state = 1'b1;
        op       = op_read(A_STATUS);
        case (st)
            S_ASSERT:  op = op_write(A_DEVCTL, CTL_HD15 | CTL_NIEN | CTL_SRST);
            S_RELEASE: op = op_write(A_DEVCTL, CTL_HD15 | CTL_NIEN);
            S_BSY_RD,
            S_SEL_BSY,
            S_RDY_RD:  op = op_read(A_STATUS);
            S_SEL1:    op = op_write(A_DEVHEAD, DH_DEV1);
            S_DH_RD:   op = op_read(A_DEVHEAD);
            S_SEL0:    op = op_write(A_DEVHEAD, DH_DEV0);
            S_REARM:   op = op_write(A_DEVCTL, CTL_HD15);
            default:   op_state = 1'b0;
        endcase
    end

    assign issue = op_state && !pend;

    // Deadline restarts at the entry of each bounded wait phase.
    always_comb begin
        dl_clr = 1'b0;
        if (xfer_done) begin
            case (st)
                S_RELEASE: dl_clr = 1'b1;
                S_BSY_RD:  dl_clr = !rd_busy;
                S_SEL0:    dl_clr = ata_q;
                default:   dl_clr = 1'b0;
            endcase
        end
    end

    assign dly_clr = xfer_done && (st == S_SEL1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            pend   <= 1'b0;
            ata_q  <= 1'b0;
            fail_q <= 1'b0;
            stat_q <= 8'h00;
        end else begin
            if (xfer_done) begin
                pend <= 1'b0;
            end else if (issue) begin
                pend <= 1'b1;
            end

            case (st)
                S_IDLE: begin
                    if (start) begin
                        ata_q  <= drive_is_ata;
                        fail_q <= 1'b0;
                        st     <= S_ASSERT;
                    end
                end
                S_ASSERT: begin
                    if (xfer_done) st <= S_RELEASE;
                end
                S_RELEASE: begin
                    if (xfer_done) st <= S_BSY_RD;
                end
                S_BSY_RD: begin
                    if (xfer_done) begin
                        stat_q <= xfer_rdata;
                        if (!rd_busy) begin
                            st <= S_SEL1;
                        end else if (dl_exp) begin
                            fail_q <= 1'b1;
                            st     <= S_REARM;
                        end
                    end
                end
                S_SEL1: begin
                    if (xfer_done) st <= S_SEL_DLY;
                end
                S_SEL_DLY: begin
                    if (dly_exp) st <= S_SEL_BSY;
                end
                S_SEL_BSY: begin
                    if (xfer_done) begin
                        stat_q <= xfer_rdata;
                        if (!rd_busy) begin
                            st <= S_DH_RD;
                        end else if (dl_exp) begin
                            fail_q <= 1'b1;
                            st     <= S_REARM;
                        end
                    end
                end
                S_DH_RD: begin
                    if (xfer_done) begin
                        if (dh_match) begin
                            st <= S_SEL0;
                        end else if (dl_exp) begin
                            fail_q <= 1'b1;
                            st     <= S_REARM;
                        end else begin
                            st <= S_SEL1;
                        end
                    end
                end
                S_SEL0: begin
                    if (xfer_done) st <= ata_q ? S_RDY_RD : S_REARM;
                end
                S_RDY_RD: begin
                    if (xfer_done) begin
                        stat_q <= xfer_rdata;
                        if (rd_ready) begin
                            st <= S_REARM;
                        end else if (dl_exp) begin
                            fail_q <= 1'b1;
                            st     <= S_REARM;
                        end
                    end
                end
                S_REARM: begin
                    if (xfer_done) st <= S_REPORT;
                end
                S_REPORT: st <= S_IDLE;
                default:  st <= S_IDLE;
            endcase
        end
    end

    assign done    = (st == S_REPORT) && !fail_q;
    assign timeout = (st == S_REPORT) && fail_q;
    assign status  = stat_q;
endmodule

// File: rtl/chan_reset_seq.sv
module chan_reset_seq #(
    parameter int unsigned     DLY_CYC = 40,
    parameter longint unsigned TMO_CYC = 64'd3_200_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       drive_is_ata,
    output logic       bus_req,
    output logic       bus_wr,
    output logic [2:0] bus_addr,
    output logic [7:0] bus_wdata,
    input  logic       bus_ack,
    input  logic [7:0] bus_rdata,
    output logic       done,
    output logic       timeout,
    output logic [7:0] status
);
    import chan_rst_pkg::*;

    localparam longint unsigned DLY_L = 64'(DLY_CYC);

    logic    issue;
    bus_op_t op;
    logic    xfer_done;
    byte_t   xfer_rdata;
    logic    dly_clr;
    logic    dly_exp;
    logic    dl_clr;
    logic    dl_exp;

    rst_bus_master u_bus (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .op         (op),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata),
        .bus_req    (bus_req),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata)
    );

    rst_cycle_timer #(.LIMIT(DLY_L)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .clr     (dly_clr),
        .expired (dly_exp)
    );

    rst_cycle_timer #(.LIMIT(TMO_CYC)) u_deadline (
        .clk     (clk),
        .rst     (rst),
        .clr     (dl_clr),
        .expired (dl_exp)
    );

    rst_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .drive_is_ata (drive_is_ata),
        .xfer_done    (xfer_done),
        .xfer_rdata   (xfer_rdata),
        .issue        (issue),
        .op           (op),
        .dly_clr      (dly_clr),
        .dly_exp      (dly_exp),
        .dl_clr       (dl_clr),
        .dl_exp       (dl_exp),
        .done         (done),
        .timeout      (timeout),
        .status       (status)
    );
endmodule

// File: rtl/chan_reset_seq_chk.sv
module chan_reset_seq_chk
    import chan_rst_pkg::*;
#(
    parameter int unsigned DLY_CYC = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_ack,
    input logic       done,
    input logic       timeout
);
    logic [10:0] last_wr;
    logic        sel_arm;
    logic [15:0] sel_cnt;
    logic        wr_ack;
    logic        sel1_ack;
    logic        stat_req;

    assign wr_ack   = bus_req && bus_ack && bus_wr;
    assign sel1_ack = wr_ack && (bus_addr == A_DEVHEAD) && (bus_wdata == DH_DEV1);
    assign stat_req = bus_req && !bus_wr && (bus_addr == A_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_wr <= '0;
            sel_arm <= 1'b0;
            sel_cnt <= '0;
        end else begin
            if (wr_ack) last_wr <= {bus_addr, bus_wdata};
            if (sel1_ack) begin
                sel_arm <= 1'b1;
                sel_cnt <= '0;
            end else begin
                if (sel_cnt != 16'hFFFF) sel_cnt <= sel_cnt + 1'b1;
                if (stat_req && bus_ack) sel_arm <= 1'b0;
            end
        end
    end

    AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |=> !bus_req); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata))); // R2

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (sel_arm && stat_req) |-> (32'(sel_cnt) >= DLY_CYC)); // R5

    AST_REARM_LAST: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |-> (last_wr == {A_DEVCTL, CTL_HD15})); // R9

    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R11

    AST_DONE_SHORT: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_TMO_SHORT: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout); // R11
endmodule

bind chan_reset_seq chan_reset_seq_chk #(.DLY_CYC(DLY_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .timeout   (timeout)
);

// File: tb/chan_reset_seq_tb_top.sv
`timescale 1ns/1ps
module chan_reset_seq_tb_top;
    localparam int DLY = 5;
    localparam int TMO = 300;

    localparam logic [2:0] AD_CTL = 3'd2;
    localparam logic [2:0] AD_DH  = 3'd6;
    localparam logic [2:0] AD_ST  = 3'd7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       drive_is_ata = 1'b0;
    logic       bus_req, bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic       done, timeout;
    logic [7:0] status;

    always #5 clk = ~clk;

    chan_reset_seq #(.DLY_CYC(DLY), .TMO_CYC(64'(TMO))) dut_i (
        .clk(clk), .rst(rst), .start(start), .drive_is_ata(drive_is_ata),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .timeout(timeout), .status(status)
    );

    int n_cmp = 0;
    int n_bad = 0;
    longint cyc = 0;

    logic [10:0] exp_wr[$];
    string       exp_wr_tag[$];
    logic [8:0]  exp_res[$];
    string       exp_res_tag[$];

    // device model state
    int         bsy_left = 0;
    logic [7:0] idle_stat = 8'h50;
    int         stick = 0;
    logic [7:0] dh_reg = 8'hA0;
    logic [7:0] ctl_reg = 8'h00;
    bit         chk_wr = 1'b0;
    bit         sel_arm = 1'b0;
    longint     sel_t = 0;
    int         n_res = 0;
    int         n_wr = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_wr(logic [2:0] a, logic [7:0] d, string tag);
        exp_wr.push_back({a, d});
        exp_wr_tag.push_back(tag);
    endtask

    task automatic push_res(bit tmo, logic [7:0] s, string tag);
        exp_res.push_back({tmo, s});
        exp_res_tag.push_back(tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Device model, write scoreboard and result monitor.
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_wr) begin
                n_wr++;
                if (chk_wr) begin
                    if (exp_wr.size() == 0) begin
                        check(1'b0, "R3", "unexpected write", int'({bus_addr, bus_wdata}), 0);
                    end else begin
                        logic [10:0] e;
                        string t;
                        e = exp_wr.pop_front();
                        t = exp_wr_tag.pop_front();
                        check({bus_addr, bus_wdata} == e, t, "write addr/data",
                              int'({bus_addr, bus_wdata}), int'(e));
                    end
                end
                if (bus_addr == AD_CTL) ctl_reg = bus_wdata;
                if (bus_addr == AD_DH) begin
                    if (bus_wdata == 8'hB0) begin
                        sel_arm = 1'b1;
                        sel_t = cyc;
                    end
                    if (stick > 0 && bus_wdata == 8'hB0) stick--;
                    else dh_reg = bus_wdata;
                end
            end else begin
                case (bus_addr)
                    AD_ST: begin
                        if (sel_arm) begin
                            check((cyc - sel_t) >= DLY, "R5", "settle gap cycles",
                                  int'(cyc - sel_t), DLY);
                            sel_arm = 1'b0;
                        end
                        if (bsy_left > 0) begin
                            bus_rdata = 8'h80;
                            bsy_left--;
                        end else begin
                            bus_rdata = idle_stat;
                        end
                    end
                    AD_DH:   bus_rdata = dh_reg;
                    default: bus_rdata = 8'h00;
                endcase
            end
        end else begin
            bus_ack = 1'b0;
        end

        if (!rst && (done || timeout)) begin
            n_res++;
            check(!(done && timeout), "R11", "done and timeout together", 1, 0);
            if (exp_res.size() == 0) begin
                check(1'b0, "R12", "unexpected result", int'({timeout, status}), 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_res.pop_front();
                t = exp_res_tag.pop_front();
                check({timeout, status} == e, t, "result {timeout,status}",
                      int'({timeout, status}), int'(e));
            end
        end
    end

    task automatic run_case(bit ata, int bsy, logic [7:0] idle, int stk, bit cw,
                            bit restart, logic [7:0] exp_dh, string dh_tag);
        int target;
        bsy_left  = bsy;
        idle_stat = idle;
        stick     = stk;
        chk_wr    = cw;
        n_wr      = 0;
        target    = n_res + 1;
        @(negedge clk);
        drive_is_ata = ata;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive_is_ata = ~ata;
        if (restart) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 20000 && n_res < target; i++) @(negedge clk);
        check(n_res == target, "R10", "result count", n_res, target);
        if (cw) check(exp_wr.size() == 0, "R2", "writes still expected", exp_wr.size(), 0);
        check(ctl_reg == 8'h08, "R9", "final device control", ctl_reg, 8'h08);
        check(dh_reg == exp_dh, dh_tag, "device/head at end", dh_reg, exp_dh);
        exp_wr.delete();
        exp_wr_tag.delete();
        repeat (20) @(negedge clk);
        check(n_res == target, "R12", "results after idle gap", n_res, target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", 150000, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(bus_req == 1'b0, "R1", "bus_req in reset", bus_req, 0);
        check(done == 1'b0 && timeout == 1'b0, "R1", "pulses in reset", {done, timeout}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(status == 8'h00, "R1", "status after reset", status, 0);
        check(bus_req == 1'b0, "R1", "bus_req idle", bus_req, 0);

        // Non-packet drive, short busy period, select works first time.
        push_wr(AD_CTL, 8'h0E, "R3"); push_wr(AD_CTL, 8'h0A, "R3");
        push_wr(AD_DH, 8'hB0, "R5");  push_wr(AD_DH, 8'hA0, "R7");
        push_wr(AD_CTL, 8'h08, "R9");
        push_res(1'b0, 8'h50, "R11");
        run_case(1'b1, 3, 8'h50, 0, 1'b1, 1'b0, 8'hA0, "R7");
        check(bsy_left == 0, "R4", "busy reads consumed", bsy_left, 0);
        check(n_wr == 5, "R2", "write accesses", n_wr, 5);

        // Packet drive, ready clear: no ready wait.
        push_wr(AD_CTL, 8'h0E, "R3"); push_wr(AD_CTL, 8'h0A, "R3");
        push_wr(AD_DH, 8'hB0, "R5");  push_wr(AD_DH, 8'hA0, "R7");
        push_wr(AD_CTL, 8'h08, "R9");
        push_res(1'b0, 8'h00, "R8");
        run_case(1'b0, 2, 8'h00, 0, 1'b1, 1'b0, 8'hA0, "R7");

        // Device ignores the first two device-1 selects.
        push_wr(AD_CTL, 8'h0E, "R3"); push_wr(AD_CTL, 8'h0A, "R3");
        push_wr(AD_DH, 8'hB0, "R6");  push_wr(AD_DH, 8'hB0, "R6");
        push_wr(AD_DH, 8'hB0, "R6");  push_wr(AD_DH, 8'hA0, "R7");
        push_wr(AD_CTL, 8'h08, "R9");
        push_res(1'b0, 8'h50, "R6");
        run_case(1'b1, 1, 8'h50, 2, 1'b1, 1'b0, 8'hA0, "R7");

        // Busy forever: timeout, interrupts still re-enabled.
        push_wr(AD_CTL, 8'h0E, "R3"); push_wr(AD_CTL, 8'h0A, "R3");
        push_wr(AD_CTL, 8'h08, "R9");
        push_res(1'b1, 8'h80, "R10");
        run_case(1'b1, 1000000, 8'h50, 0, 1'b1, 1'b0, 8'hA0, "R4");

        // Non-packet drive that never reports ready.
        push_wr(AD_CTL, 8'h0E, "R3"); push_wr(AD_CTL, 8'h0A, "R3");
        push_wr(AD_DH, 8'hB0, "R5");  push_wr(AD_DH, 8'hA0, "R7");
        push_wr(AD_CTL, 8'h08, "R9");
        push_res(1'b1, 8'h00, "R8");
        run_case(1'b1, 0, 8'h00, 0, 1'b1, 1'b0, 8'hA0, "R7");

        // Device 1 never selectable: deadline on the retry loop.
        dh_reg = 8'hA0;
        push_res(1'b1, 8'h50, "R6");
        run_case(1'b1, 0, 8'h50, 1000000, 1'b0, 1'b0, 8'hA0, "R6");

        // Second start in mid-run is ignored.
        push_wr(AD_CTL, 8'h0E, "R12"); push_wr(AD_CTL, 8'h0A, "R12");
        push_wr(AD_DH, 8'hB0, "R12");  push_wr(AD_DH, 8'hA0, "R12");
        push_wr(AD_CTL, 8'h08, "R12");
        push_res(1'b0, 8'h50, "R12");
        run_case(1'b1, 2, 8'h50, 0, 1'b1, 1'b1, 8'hA0, "R7");
        check(n_wr == 5, "R12", "write accesses with extra start", n_wr, 5);

        summary();
    end
endmodule